// File: doc/BRIEF.md
# Selectable Link Event Counter Bank

This block holds the event counters for a serial link controller, one counter per (group, event, lane) combination. Event strobes come in as plain single-cycle pulses, sorted by protocol layer into five groups. Groups 0 and 4 are per lane and carry one strobe per lane for each event. Groups 1 to 3 carry one strobe per event.

Software reaches the counters through two registers in a small window. A control register at offset 0x8 names the counter of interest with a group, event and lane field. The same register carries a command that switches that counter on or off, and a status flag that shows whether the selected counter is running. A data register at offset 0xC returns the selected counter's value. To clear a counter, software switches it off and then on again.

Each counter is a two-state machine. Its states are `CELL_OFF` and `CELL_ON`.
- Transition OFF→ON happens on an enable command and clears the count.
- Transition ON→OFF happens on a disable command and keeps the count.
- In `CELL_ON` the counter steps on every strobe cycle and stops at all-ones.
- In `CELL_OFF` the count is frozen.

Top module: `ecb_top`

## Requirements
- R1: After reset every counter is in `CELL_OFF` with count zero, and the control register reads 0x0000_0000 (group 0, event 0, lane 0, status 0).
- R2: A write to offset 0x8 stores the group in bits [27:24], the event in bits [23:16] and the lane in bits [11:8], and these read back as written. Bits other than 7 and [4:2] also read back as written. The command bits [4:2] read as zero. Bit 7 reads the status of the selected counter, and a write to it is ignored.
- R3: Command 3'b011 in bits [4:2] switches on the counter named by the fields of that same write. If that counter was off, its count becomes zero. If it was already on, its count is left alone.
- R4: Command 3'b001 switches the named counter off. Its count stays frozen and readable, and strobes no longer change it.
- R5: Any other command value changes no counter's state or count.
- R6: A running counter adds one for each clock cycle in which its strobe is high.
- R7: A running counter stops at the all-ones value of CNT_W bits instead of wrapping.
- R8: A read at offset 0xC returns the count of the selected counter, zero-extended to 32 bits.
- R9: Groups 0 and 4 are per lane, and the lane field picks the counter; group 0 strobe bit lane*11+event, group 4 strobe bit lane*2+event. Groups 1 to 3 ignore the lane field. The group 1 strobe bits 0..7 carry events 5,6,7,8,9,10,12,13. The group 2 and group 3 strobe bit number equals the event number.
- R10: These pairs are unimplemented: group 1 event 11, events outside the ranges (group 0: 0–10, group 1: 5–13, group 2: 0–7, group 3: 0–5, group 4: 0–1), groups above 4, and lanes at or above NUM_LANES in groups 0 and 4. An unimplemented selection reads status 0 and data 0, and commands to it change no counter.
- R11: Writes to any offset other than 0x8 are ignored, and reads from offsets other than 0x8 and 0xC return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ev_g0 | input | 11*NUM_LANES | Group 0 strobes, bit lane*11+event |
| ev_g1 | input | 8 | Group 1 strobes for events 5..10,12,13 |
| ev_g2 | input | 8 | Group 2 strobes, bit = event |
| ev_g3 | input | 6 | Group 3 strobes, bit = event |
| ev_g4 | input | 2*NUM_LANES | Group 4 strobes, bit lane*2+event |

## Verification
Directed sequences hold one strobe high for a known number of cycles, then read the count.
- A disable followed by more strobes shows that a frozen counter ignores its input.
- A repeated enable tells a true 0→1 clear apart from an enable on a counter that is already running.
- Driving lane 0 and lane 1 together while only lane 1 is enabled separates the per-lane counters.
- Selecting group 2 with a non-zero lane shows that the lane field is ignored in that group.

A long random phase then drives random strobes on every input at once, mixed with random selects and commands, including unimplemented pairs and unknown codes. A bench model predicts every control and data read. A sweep of every implemented counter at the end catches any strobe routed to the wrong counter.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    typedef enum logic {
        CELL_OFF = 1'b0,
        CELL_ON  = 1'b1
    } cell_state_e;

    localparam logic [2:0] CMD_ON  = 3'b011;
    localparam logic [2:0] CMD_OFF = 3'b001;

    localparam int CTRL_OFS = 8;
    localparam int DATA_OFS = 12;

    // Written control bits that are stored: all but status [7] and command [4:2]
    localparam logic [31:0] CTRL_KEEP = 32'hFFFF_FF63;

    localparam int G0_EVENTS = 11;
    localparam int G1_EVENTS = 8;
    localparam int G2_EVENTS = 8;
    localparam int G3_EVENTS = 6;
    localparam int G4_EVENTS = 2;
    localparam int G1_FIRST  = 5;
    localparam int G1_HOLE   = 11;
    localparam int G1_LAST   = 13;

endpackage

// File: rtl/ecb_map.sv
module ecb_map #(
    parameter int NUM_LANES = 4,
    parameter int IDX_W     = 7
) (
    input  logic [3:0]       grp,
    input  logic [7:0]       evt,
    input  logic [3:0]       lane,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    import ecb_pkg::*;

    localparam int G1_BASE = G0_EVENTS * NUM_LANES;
    localparam int G2_BASE = G1_BASE + G1_EVENTS;
    localparam int G3_BASE = G2_BASE + G2_EVENTS;
    localparam int G4_BASE = G3_BASE + G3_EVENTS;

    int e_i;
    int l_i;
    int lin;

    always_comb begin
        e_i = int'(evt);
        l_i = int'(lane);
        hit = 1'b0;
        lin = 0;
        case (grp)
            4'd0: begin
                hit = (e_i < G0_EVENTS) && (l_i < NUM_LANES);
                lin = l_i * G0_EVENTS + e_i;
            end
            4'd1: begin
                hit = (e_i >= G1_FIRST) && (e_i <= G1_LAST) && (e_i != G1_HOLE);
                lin = G1_BASE + e_i - G1_FIRST - ((e_i > G1_HOLE) ? 1 : 0);
            end
            4'd2: begin
                hit = (e_i < G2_EVENTS);
                lin = G2_BASE + e_i;
            end
            4'd3: begin
                hit = (e_i < G3_EVENTS);
                lin = G3_BASE + e_i;
            end
            4'd4: begin
                hit = (e_i < G4_EVENTS) && (l_i < NUM_LANES);
                lin = G4_BASE + l_i * G4_EVENTS + e_i;
            end
            default: begin
                hit = 1'b0;
                lin = 0;
            end
        endcase
        idx = hit ? IDX_W'(lin) : '0;
    end

endmodule

// File: rtl/ecb_cell.sv
module ecb_cell #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             strobe,
    output logic             on,
    output logic [CNT_W-1:0] count
);
    import ecb_pkg::*;

    cell_state_e state_q;
    cell_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_OFF: state_d = en_cmd  ? CELL_ON  : CELL_OFF;
            CELL_ON:  state_d = dis_cmd ? CELL_OFF : CELL_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (state_q == CELL_OFF && en_cmd) begin
            count <= '0;
        end else if (state_q == CELL_ON && strobe && count != '1) begin
            count <= count + 1'b1;
        end
    end

    assign on = (state_q == CELL_ON);

    assert_clear_on_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && en_cmd) |=> (on && count == '0));

    assert_frozen_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!on && !en_cmd) |=> $stable(count));

    assert_disable_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (on && dis_cmd) |=> !on);

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (on && strobe && count != '1) |=> (count == $past(count) + 1'b1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (on && count == '1) |=> (count == '1));

endmodule

// File: rtl/ecb_top.sv
module ecb_top #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 32,   // at most 32
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [11*NUM_LANES-1:0] ev_g0,
    input  logic [7:0]             ev_g1,
    input  logic [7:0]             ev_g2,
    input  logic [5:0]             ev_g3,
    input  logic [2*NUM_LANES-1:0] ev_g4
);
    import ecb_pkg::*;

    localparam int NUM_CNT = (G0_EVENTS + G4_EVENTS) * NUM_LANES
                           + G1_EVENTS + G2_EVENTS + G3_EVENTS;
    localparam int IDX_W   = $clog2(NUM_CNT);

    logic [31:0]        ctrl_q;
    logic               ctrl_wr;
    logic [2:0]         cmd;
    logic               cmd_on;
    logic               cmd_off;
    logic               wr_hit;
    logic [IDX_W-1:0]   wr_idx;
    logic               rd_hit;
    logic [IDX_W-1:0]   rd_idx;
    logic [NUM_CNT-1:0] strobe_all;
    logic [NUM_CNT-1:0] en_vec;
    logic [NUM_CNT-1:0] dis_vec;
    logic [NUM_CNT-1:0] on_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
    logic [CNT_W-1:0]   sel_cnt;
    logic               status;

    assign ctrl_wr    = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    assign cmd        = reg_wdata[4:2];
    assign cmd_on     = ctrl_wr && (cmd == CMD_ON);
    assign cmd_off    = ctrl_wr && (cmd == CMD_OFF);
    assign strobe_all = {ev_g4, ev_g3, ev_g2, ev_g1, ev_g0};

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_KEEP;
    end

    // Target of a command: fields carried in the same write
    ecb_map #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_map_wr (
        .grp  (reg_wdata[27:24]),
        .evt  (reg_wdata[23:16]),
        .lane (reg_wdata[11:8]),
        .hit  (wr_hit),
        .idx  (wr_idx)
    );

    // Counter shown on readback: stored fields
    ecb_map #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_map_rd (
        .grp  (ctrl_q[27:24]),
        .evt  (ctrl_q[23:16]),
        .lane (ctrl_q[11:8]),
        .hit  (rd_hit),
        .idx  (rd_idx)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
        assign en_vec[i]  = cmd_on  && wr_hit && (wr_idx == IDX_W'(i));
        assign dis_vec[i] = cmd_off && wr_hit && (wr_idx == IDX_W'(i));
        ecb_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_cmd  (en_vec[i]),
            .dis_cmd (dis_vec[i]),
            .strobe  (strobe_all[i]),
            .on      (on_vec[i]),
            .count   (cnt_arr[i])
        );
    end

    assign sel_cnt = rd_hit ? cnt_arr[rd_idx] : '0;
    assign status  = rd_hit && on_vec[rd_idx];

    always_comb begin
        if (reg_addr == ADDR_W'(CTRL_OFS))
            reg_rdata = {ctrl_q[31:8], status, ctrl_q[6:0]};
        else if (reg_addr == ADDR_W'(DATA_OFS))
            reg_rdata = 32'(sel_cnt);
        else
            reg_rdata = '0;
    end

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_vec | dis_vec));

    assert_unknown_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd != CMD_ON && cmd != CMD_OFF) |=> $stable(on_vec));

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_hit) |=> $stable(on_vec));

    assert_other_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ctrl_wr) |=> ($stable(ctrl_q) && $stable(on_vec)));

endmodule

// File: tb/tb_ecb_top.sv
module tb_ecb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL   = 4;
    localparam int CW   = 8;
    localparam int NC   = 13 * NL + 22;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = 4'h0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [11*NL-1:0] ev_g0 = '0;
    logic [7:0]    ev_g1 = '0;
    logic [7:0]    ev_g2 = '0;
    logic [5:0]    ev_g3 = '0;
    logic [2*NL-1:0] ev_g4 = '0;

    int unsigned m_cnt [NC];
    bit          m_on  [NC];
    logic [31:0] m_ctrl;
    int          total = 0;
    int          fails = 0;
    bit          done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecb_top #(.NUM_LANES(NL), .CNT_W(CW), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_g0(ev_g0), .ev_g1(ev_g1), .ev_g2(ev_g2), .ev_g3(ev_g3), .ev_g4(ev_g4)
    );

    function automatic bit f_valid(int g, int e, int l);
        case (g)
            0: return (e < 11) && (l < NL);
            1: return (e >= 5) && (e <= 13) && (e != 11);
            2: return e < 8;
            3: return e < 6;
            4: return (e < 2) && (l < NL);
            default: return 0;
        endcase
    endfunction

    function automatic int f_idx(int g, int e, int l);
        case (g)
            0: return l * 11 + e;
            1: return NL * 11 + ((e < 11) ? e - 5 : e - 6);
            2: return NL * 11 + 8 + e;
            3: return NL * 11 + 16 + e;
            default: return NL * 11 + 22 + l * 2 + e;
        endcase
    endfunction

    function automatic logic [31:0] exp_ctrl();
        int g = int'(m_ctrl[27:24]);
        int e = int'(m_ctrl[23:16]);
        int l = int'(m_ctrl[11:8]);
        bit st = f_valid(g, e, l) && m_on[f_idx(g, e, l)];
        return m_ctrl | (32'(st) << 7);
    endfunction

    function automatic logic [31:0] exp_data();
        int g = int'(m_ctrl[27:24]);
        int e = int'(m_ctrl[23:16]);
        int l = int'(m_ctrl[11:8]);
        return f_valid(g, e, l) ? 32'(m_cnt[f_idx(g, e, l)]) : 32'h0;
    endfunction

    task automatic model_update();
        logic [NC-1:0] sv = {ev_g4, ev_g3, ev_g2, ev_g1, ev_g0};
        bit wc = reg_wr && reg_addr == 4'h8;
        int g = int'(reg_wdata[27:24]);
        int e = int'(reg_wdata[23:16]);
        int l = int'(reg_wdata[11:8]);
        int c = int'(reg_wdata[4:2]);
        bit tv = f_valid(g, e, l);
        int ti = tv ? f_idx(g, e, l) : -1;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_on[i] = 0; end
            m_ctrl = '0;
            return;
        end
        for (int i = 0; i < NC; i++) begin
            if (!m_on[i] && wc && c == 3 && ti == i) begin
                m_on[i] = 1; m_cnt[i] = 0;
            end else begin
                if (m_on[i] && sv[i] && m_cnt[i] != MAXC) m_cnt[i]++;
                if (m_on[i] && wc && c == 1 && ti == i) m_on[i] = 0;
            end
        end
        if (wc) m_ctrl = reg_wdata & 32'hFFFF_FF63;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        reg_wr = 1'b0;
        ev_g0 = '0; ev_g1 = '0; ev_g2 = '0; ev_g3 = '0; ev_g4 = '0;
    endtask

    task automatic chk(logic [31:0] got, logic [31:0] exp, string req);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr_ctrl(int g, int e, int l, int c);
        reg_wr = 1'b1;
        reg_addr = 4'h8;
        reg_wdata = (32'(g) << 24) | (32'(e & 255) << 16) | (32'(l) << 8) | (32'(c & 7) << 2);
        cycle();
    endtask

    task automatic check_both(string req);
        logic [31:0] v;
        rd(4'h8, v); chk(v, exp_ctrl(), req);
        rd(4'hC, v); chk(v, exp_data(), req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = $urandom(32'd2718);
        @(negedge clk);
        cycle(); cycle(); cycle();
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h8, v); chk(v, 32'h0, "R1 ctrl");
        rd(4'hC, v); chk(v, 32'h0, "R1 data");

        // R6 R8 count a group 2 event
        wr_ctrl(2, 3, 0, 3);
        repeat (5) begin ev_g2[3] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd5, "R6 count five");
        rd(4'h8, v); chk(v, 32'h0203_0080, "R2 status on");

        // R2 readback, reserved bit, cmd reads 0; R5 cmd 111; R9 lane ignored in g2
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8203_059C; cycle();
        rd(4'h8, v); chk(v, 32'h8203_0580, "R2 fields readback");
        rd(4'hC, v); chk(v, 32'd5, "R9 lane ignored group2");

        // R4 disable freezes
        wr_ctrl(2, 3, 0, 1);
        repeat (3) begin ev_g2[3] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd5, "R4 frozen count");
        rd(4'h8, v); chk(v, 32'h0203_0000, "R4 status off");

        // R3 re-enable clears, enable while on keeps
        wr_ctrl(2, 3, 0, 3);
        rd(4'hC, v); chk(v, 32'd0, "R3 clear on enable");
        repeat (2) begin ev_g2[3] = 1'b1; cycle(); end
        wr_ctrl(2, 3, 0, 3);
        rd(4'hC, v); chk(v, 32'd2, "R3 enable while on keeps");

        // R5 unknown codes
        wr_ctrl(2, 3, 0, 2);
        ev_g2[3] = 1'b1; cycle();
        rd(4'h8, v); chk(v, 32'h0203_0080, "R5 cmd 010 keeps on");
        rd(4'hC, v); chk(v, 32'd3, "R5 still counting");
        wr_ctrl(2, 4, 0, 5);
        rd(4'h8, v); chk(v, 32'h0204_0000, "R5 cmd 101 keeps off");

        // R7 saturation
        wr_ctrl(3, 0, 0, 3);
        repeat (300) begin ev_g3[0] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd255, "R7 saturate");
        ev_g3[0] = 1'b1; cycle();
        rd(4'hC, v); chk(v, 32'd255, "R7 stays saturated");

        // R9 per lane
        wr_ctrl(0, 2, 1, 3);
        repeat (4) begin ev_g0[13] = 1'b1; ev_g0[2] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd4, "R9 lane1 count");
        wr_ctrl(0, 2, 0, 0);
        rd(4'hC, v); chk(v, 32'd0, "R9 lane0 untouched");
        rd(4'h8, v); chk(v, 32'h0002_0000, "R9 lane0 off");
        wr_ctrl(4, 1, 3, 3);
        repeat (2) begin ev_g4[7] = 1'b1; ev_g4[6] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd2, "R9 group4 lane3");
        wr_ctrl(1, 12, 0, 3);
        repeat (3) begin ev_g1[6] = 1'b1; ev_g1[5] = 1'b1; cycle(); end
        rd(4'hC, v); chk(v, 32'd3, "R9 group1 event12 bit6");

        // R10 unimplemented
        wr_ctrl(1, 11, 0, 3);
        rd(4'h8, v); chk(v, 32'h010B_0000, "R10 hole status");
        rd(4'hC, v); chk(v, 32'h0, "R10 hole data");
        wr_ctrl(0, 2, 4, 3);
        rd(4'h8, v); chk(v, 32'h0002_0400, "R10 lane out of range");
        wr_ctrl(5, 0, 0, 3);
        rd(4'h8, v); chk(v, 32'h0500_0000, "R10 group 5");
        wr_ctrl(1, 12, 0, 0);
        rd(4'h8, v); chk(v, 32'h010C_0080, "R10 other counter unaffected");
        rd(4'hC, v); chk(v, 32'd3, "R10 other count unaffected");

        // R11 other offsets
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'hFFFF_FFFF; cycle();
        rd(4'h8, v); chk(v, 32'h010C_0080, "R11 write ignored");
        rd(4'h4, v); chk(v, 32'h0, "R11 read zero");

        // Random phase against the bench model (R2 R3 R4 R5 R6 R8 R10)
        for (int n = 0; n < 4000; n++) begin
            ev_g0 = 44'($urandom) ^ (44'($urandom) << 20);
            ev_g1 = 8'($urandom); ev_g2 = 8'($urandom);
            ev_g3 = 6'($urandom); ev_g4 = 8'($urandom);
            if ($urandom % 8 == 0) begin
                int k = int'($urandom % 6);
                int c = (k < 2) ? 3 : (k < 4) ? 1 : (k == 4) ? 0 : int'($urandom % 8);
                wr_ctrl(int'($urandom % 6), int'($urandom % 15), int'($urandom % 6), c);
                check_both("R8 random");
            end else begin
                cycle();
            end
        end

        // Final sweep of all implemented counters (R8 R9)
        for (int g = 0; g < 5; g++)
            for (int e = 0; e < 14; e++)
                for (int l = 0; l < NL; l++)
                    if (f_valid(g, e, l)) begin
                        wr_ctrl(g, e, l, 0);
                        check_both("R9 sweep");
                    end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule